// File: doc/BRIEF.md
# Ripple-Carry Adder with Condition Flag Register

This block adds two 8-bit operands through a chain of one-bit full-adder cells. It keeps the resulting condition flags in an 8-bit status register. Two operations are offered. A plain add feeds a zero into the lowest cell. An add-with-carry feeds in the carry flag held from the previous arithmetic step, which lets wider sums be built one byte at a time. The sum is available combinationally while the operands are applied. The flags are captured on the rising clock edge in which arithmetic is enabled.

The status register also holds two bits that arithmetic never touches. The upper bit is a global interrupt enable. The bit below it is a general-purpose user bit that bit-transfer operations use. Both are loaded through a direct-write port. An interrupt-acknowledge input clears the interrupt enable.

Top module: `addc_flag_unit`

## Requirements
- R1: With `op_sel_i` = 0 (plain add), `sum_o` equals (`opa_i` + `opb_i`) modulo 256, with a carry-in of zero whatever the stored carry flag holds.
- R2: With `op_sel_i` = 1 (add-with-carry), `sum_o` equals (`opa_i` + `opb_i` + stored carry flag `sreg_o[0]`) modulo 256.
- R3: After an enabled operation, `sreg_o[0]` (carry) holds the carry out of bit 7 of that addition.
- R4: After an enabled operation, `sreg_o[5]` (half carry) holds the carry out of bit 3, which is the carry from the low nibble.
- R5: After an enabled operation, `sreg_o[2]` (negative) equals bit 7 of the sum. `sreg_o[1]` (zero) is 1 exactly when all eight sum bits are 0.
- R6: After an enabled operation, `sreg_o[3]` (overflow) is 1 when both operands share a sign and the sum's sign differs from it. `sreg_o[4]` (sign) equals negative XOR overflow.
- R7: While `op_en_i` is 0, a clock edge leaves `sreg_o[5:0]` unchanged, whatever operands are applied.
- R8: Arithmetic never changes `sreg_o[7]` or `sreg_o[6]`. When `sreg_wr_i` is 1, the clock edge loads `sreg_o[7]` from `sreg_wr_data_i[1]` and `sreg_o[6]` from `sreg_wr_data_i[0]`.
- R9: When `irq_ack_i` is 1, the clock edge clears `sreg_o[7]`. This takes priority over a direct write in the same cycle, and `sreg_o[6]` still takes its written value.
- R10: While `rst_ni` is 0, the whole status register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_en_i | input | 1 | Capture arithmetic flags on this edge |
| op_sel_i | input | 1 | 0 = plain add, 1 = add-with-carry |
| opa_i | input | 8 | First operand |
| opb_i | input | 8 | Second operand |
| irq_ack_i | input | 1 | Interrupt taken; clears the interrupt enable |
| sreg_wr_i | input | 1 | Direct write of bits 7 and 6 |
| sreg_wr_data_i | input | 2 | Write value: [1] to interrupt enable, [0] to user bit |
| sum_o | output | 8 | Combinational sum |
| sreg_o | output | 8 | Status register: I,T,H,S,V,N,Z,C from bit 7 to bit 0 |

## Verification
The assertions assume that operands, the operation select and every control input are known and steady at each rising edge. They also assume that a reset lasts at least one edge. The bench meets this by changing every input on the falling edge only. Before each add-with-carry vector, the bench preloads the carry flag with a known plain add, so the stored carry that feeds the chain is always a value the bench itself set up.

// File: rtl/addc_pkg.sv
package addc_pkg;

    // Status register, bit 7 down to bit 0.
    typedef struct packed {
        logic ie;    // global interrupt enable
        logic ub;    // user bit for bit transfers
        logic hc;    // carry out of low nibble
        logic sg;    // sign (negative xor overflow)
        logic ov;    // two's complement overflow
        logic ng;    // result bit 7
        logic zr;    // result is zero
        logic cy;    // carry out of the top bit
    } sreg_t;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_ADC = 1'b1
    } addc_op_e;

    typedef struct packed {
        sreg_t sreg;
    } addc_state_t;

endpackage

// File: rtl/addc_fa_cell.sv
module addc_fa_cell (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    logic ab_x;

    always_comb begin
        ab_x = a_i ^ b_i;
        s_o  = ab_x ^ c_i;
        c_o  = (a_i & b_i) | (ab_x & c_i);
    end
endmodule

// File: rtl/addc_ripple.sv
module addc_ripple #(
    parameter int WIDTH    = 8,
    parameter int HALF_BIT = 3
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             half_co_o,
    output logic             co_o
);
    logic [WIDTH:0] chain;

    assign chain[0] = cin_i;

    for (genvar g = 0; g < WIDTH; g++) begin : g_cell
        addc_fa_cell u_fa (
            .a_i (a_i[g]),
            .b_i (b_i[g]),
            .c_i (chain[g]),
            .s_o (sum_o[g]),
            .c_o (chain[g+1])
        );
    end

    assign half_co_o = chain[HALF_BIT+1];
    assign co_o      = chain[WIDTH];
endmodule

// File: rtl/addc_flag_gen.sv
module addc_flag_gen #(
    parameter int WIDTH = 8
) (
    input  logic             a_msb_i,
    input  logic             b_msb_i,
    input  logic [WIDTH-1:0] sum_i,
    input  logic             half_co_i,
    input  logic             co_i,
    output logic             hc_o,
    output logic             sg_o,
    output logic             ov_o,
    output logic             ng_o,
    output logic             zr_o,
    output logic             cy_o
);
    always_comb begin
        hc_o = half_co_i;
        cy_o = co_i;
        ng_o = sum_i[WIDTH-1];
        zr_o = ~|sum_i;
        ov_o = (a_msb_i == b_msb_i) && (sum_i[WIDTH-1] != a_msb_i);
        sg_o = ng_o ^ ov_o;
    end
endmodule

// File: rtl/addc_flag_unit.sv
module addc_flag_unit
    import addc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             op_en_i,
    input  logic             op_sel_i,
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic             irq_ack_i,
    input  logic             sreg_wr_i,
    input  logic [1:0]       sreg_wr_data_i,
    output logic [WIDTH-1:0] sum_o,
    output logic [7:0]       sreg_o
);
    localparam int HALF_BIT = WIDTH / 2 - 1;

    addc_state_t st_d, st_q;

    logic             cin;
    logic             half_co, co;
    logic             f_hc, f_sg, f_ov, f_ng, f_zr, f_cy;
    logic [WIDTH-1:0] sum;

    assign cin = (addc_op_e'(op_sel_i) == OP_ADC) ? st_q.sreg.cy : 1'b0;

    addc_ripple #(.WIDTH(WIDTH), .HALF_BIT(HALF_BIT)) u_add (
        .a_i       (opa_i),
        .b_i       (opb_i),
        .cin_i     (cin),
        .sum_o     (sum),
        .half_co_o (half_co),
        .co_o      (co)
    );

    addc_flag_gen #(.WIDTH(WIDTH)) u_flags (
        .a_msb_i   (opa_i[WIDTH-1]),
        .b_msb_i   (opb_i[WIDTH-1]),
        .sum_i     (sum),
        .half_co_i (half_co),
        .co_i      (co),
        .hc_o      (f_hc),
        .sg_o      (f_sg),
        .ov_o      (f_ov),
        .ng_o      (f_ng),
        .zr_o      (f_zr),
        .cy_o      (f_cy)
    );

    always_comb begin
        st_d = st_q;
        if (op_en_i) begin
            st_d.sreg.hc = f_hc;
            st_d.sreg.sg = f_sg;
            st_d.sreg.ov = f_ov;
            st_d.sreg.ng = f_ng;
            st_d.sreg.zr = f_zr;
            st_d.sreg.cy = f_cy;
        end
        if (sreg_wr_i) begin
            st_d.sreg.ie = sreg_wr_data_i[1];
            st_d.sreg.ub = sreg_wr_data_i[0];
        end
        if (irq_ack_i) begin
            st_d.sreg.ie = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sum_o  = sum;
    assign sreg_o = st_q.sreg;
endmodule

// File: rtl/addc_flag_unit_chk.sv
module addc_flag_unit_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             op_en_i,
    input logic             op_sel_i,
    input logic [WIDTH-1:0] opa_i,
    input logic [WIDTH-1:0] opb_i,
    input logic             irq_ack_i,
    input logic             sreg_wr_i,
    input logic [1:0]       sreg_wr_data_i,
    input logic [WIDTH-1:0] sum_o,
    input logic [7:0]       sreg_o
);
    logic [WIDTH:0] ref_full;
    logic           ref_cin;

    always_comb begin
        ref_cin  = op_sel_i & sreg_o[0];
        ref_full = {1'b0, opa_i} + {1'b0, opb_i} + {{WIDTH{1'b0}}, ref_cin};
    end

    // R1 R2: sum matches an arithmetic reference with the selected carry-in
    a_r1_r2_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sum_o == ref_full[WIDTH-1:0]);

    // R3: carry flag equals top carry of the enabled addition
    a_r3_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        op_en_i |=> sreg_o[0] == $past(ref_full[WIDTH]));

    // R5: zero flag follows the sum seen on the port
    a_r5_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        op_en_i |=> sreg_o[1] == ($past(sum_o) == '0));

    // R6: sign is negative xor overflow after an update
    a_r6_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
        op_en_i |=> sreg_o[4] == (sreg_o[2] ^ sreg_o[3]));

    // R7: arithmetic flags hold when disabled
    a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !op_en_i |=> $stable(sreg_o[5:0]));

    // R8: user bit changes only through a direct write
    a_r8_ub_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sreg_wr_i |=> $stable(sreg_o[6]));

    // R9: acknowledge clears the interrupt enable
    a_r9_ack_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_ack_i |=> !sreg_o[7]);
endmodule

bind addc_flag_unit addc_flag_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .op_en_i        (op_en_i),
    .op_sel_i       (op_sel_i),
    .opa_i          (opa_i),
    .opb_i          (opb_i),
    .irq_ack_i      (irq_ack_i),
    .sreg_wr_i      (sreg_wr_i),
    .sreg_wr_data_i (sreg_wr_data_i),
    .sum_o          (sum_o),
    .sreg_o         (sreg_o)
);

// File: tb/tb_addc_flag_unit.sv
module tb_addc_flag_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_en = 1'b0, op_sel = 1'b0;
    logic [7:0] opa = '0, opb = '0;
    logic       irq_ack = 1'b0, wr = 1'b0;
    logic [1:0] wr_data = '0;
    logic [7:0] sum, sreg;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    addc_flag_unit dut (
        .clk_i(clk), .rst_ni(rst_n), .op_en_i(op_en), .op_sel_i(op_sel),
        .opa_i(opa), .opb_i(opb), .irq_ack_i(irq_ack), .sreg_wr_i(wr),
        .sreg_wr_data_i(wr_data), .sum_o(sum), .sreg_o(sreg)
    );

    // {op_sel, carry preset, a, b, expected sum, expected H S V N Z C}
    localparam int NV = 11;
    localparam logic [31:0] VEC [NV] = '{
        {1'b0, 1'b0, 8'h05, 8'h08, 8'h0D, 6'h00},
        {1'b0, 1'b0, 8'h07, 8'h09, 8'h10, 6'h20},
        {1'b0, 1'b0, 8'hFF, 8'h01, 8'h00, 6'h23},
        {1'b0, 1'b0, 8'h7F, 8'h01, 8'h80, 6'h2C},
        {1'b0, 1'b0, 8'h80, 8'h80, 8'h00, 6'h1B},
        {1'b1, 1'b1, 8'h01, 8'h01, 8'h03, 6'h00},
        {1'b1, 1'b1, 8'hFF, 8'h00, 8'h00, 6'h23},
        {1'b1, 1'b0, 8'h10, 8'h20, 8'h30, 6'h00},
        {1'b0, 1'b1, 8'hF0, 8'hF0, 8'hE0, 6'h15},
        {1'b1, 1'b1, 8'h3F, 8'h40, 8'h80, 6'h2C},
        {1'b0, 1'b1, 8'hC0, 8'hC0, 8'h80, 6'h15}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic sel, input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        op_en = 1'b1; op_sel = sel; opa = a; opb = b;
        @(posedge clk);
        @(negedge clk);
        op_en = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        check("R10 reset value", sreg, 8'h00);
        rst_n = 1'b1;

        // set interrupt enable and user bit; arithmetic must leave them
        @(negedge clk);
        wr = 1'b1; wr_data = 2'b11;
        @(negedge clk);
        wr = 1'b0;
        check("R8 direct write", sreg[7:6], 8'h03);

        for (int i = 0; i < NV; i++) begin
            logic [31:0] v;
            v = VEC[i];
            // preload carry: 80+80 sets C, 00+00 clears it
            if (v[30]) do_op(1'b0, 8'h80, 8'h80);
            else       do_op(1'b0, 8'h00, 8'h00);
            op_en = 1'b1; op_sel = v[31]; opa = v[29:22]; opb = v[21:14];
            #1;
            check(v[31] ? "R2 adc sum" : "R1 add sum", sum, v[13:6]);
            @(posedge clk);
            @(negedge clk);
            op_en = 1'b0;
            check("R3 carry", {7'b0, sreg[0]}, {7'b0, v[0]});
            check("R4 half carry", {7'b0, sreg[5]}, {7'b0, v[5]});
            check("R5 negative zero", {6'b0, sreg[2:1]}, {6'b0, v[2:1]});
            check("R6 overflow sign", {6'b0, sreg[4:3]}, {6'b0, v[4:3]});
            check("R8 ie ub kept", {6'b0, sreg[7:6]}, 8'h03);
        end

        // R7: operands that would change every flag, enable low
        do_op(1'b0, 8'h80, 8'h80);
        @(negedge clk);
        op_en = 1'b0; op_sel = 1'b0; opa = 8'h07; opb = 8'h09;
        @(posedge clk);
        @(negedge clk);
        check("R7 hold while disabled", {2'b0, sreg[5:0]}, 8'h1B);

        // R9: acknowledge beats a write of the enable bit
        wr = 1'b1; wr_data = 2'b10; irq_ack = 1'b1;
        @(negedge clk);
        wr = 1'b0; irq_ack = 1'b0;
        check("R9 ack over write", {6'b0, sreg[7:6]}, 8'h00);
        wr = 1'b1; wr_data = 2'b10;
        @(negedge clk);
        wr = 1'b0;
        check("R8 write ie only", {6'b0, sreg[7:6]}, 8'h02);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        check("R9 ack alone", {6'b0, sreg[7:6]}, 8'h00);
        wr = 1'b1; wr_data = 2'b11; irq_ack = 1'b1;
        @(negedge clk);
        wr = 1'b0; irq_ack = 1'b0;
        check("R9 ack keeps ub write", {6'b0, sreg[7:6]}, 8'h01);

        // R10: reset in mid-run clears everything
        do_op(1'b0, 8'hFF, 8'h01);
        rst_n = 1'b0;
        #1;
        check("R10 reset mid-run", sreg, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        op_sel = 1'b1; opa = 8'h01; opb = 8'h01;
        #1;
        check("R2 carry cleared by reset", sum, 8'h02);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule